// File: doc/BRIEF.md
# Control-Line Handshake and Interrupt Unit

This block manages the two control lines that accompany an 8-bit parallel I/O port. Line A is input-only and has a selectable active edge. Line B is set up by a 3-bit mode. It can be an edge input that clears together with the port, an edge input that raises an independent interrupt, an automatic handshake output, a one-cycle pulse output, or a fixed low or high level. The block does not hold the port data register. It sees only the read and write strobes of that register, and uses them to clear flags and to drive the handshake and pulse sequences on line B.

A host reaches three 8-bit registers through a small select/write/read interface. The control register holds the edge select for line A and the mode for line B. The flag register records detected edges, and its bit 7 summarises the flags that are enabled. The enable register uses a set/clear write convention. The interrupt output is the OR of all flags whose enable bit is set. Both external lines pass through a synchroniser before edge detection, so the lines may be fully asynchronous to the clock.

Top module: `ctl_handshake_irq`

## Requirements
- R1: After reset, line_b_out is 1, line_b_oe is 0 and irq is 0. The control and flag registers read 0x00 and the enable register reads 0x80.
- R2: A line A edge of the kind chosen by control bit 0 (0 = falling, 1 = rising) sets flag bit 1. The flag is visible three clock edges after the input changes. An edge of the other kind sets nothing.
- R3: In line B modes 000 (falling) and 010 (rising), the matching edge sets flag bit 0. A port read or write then clears that flag.
- R4: In line B modes 001 (falling) and 011 (rising), the matching edge sets flag bit 0. A port access leaves the flag set, and only writing 1 to flag register bit 0 clears it.
- R5: A port access clears flag bit 1. Writing 1 to a flag register bit clears that flag. Writing 0 bits, or writing bit 7, changes nothing.
- R6: A write to the enable register with bit 7 = 1 sets the enables given by the 1s in bits 6..0. With bit 7 = 0 it clears them. A read returns bit 7 as 1.
- R7: irq, and bit 7 of the flag register read, are 1 exactly when some flag bit and its enable bit are both 1.
- R8: In line B mode 100, a port access drives line_b_out low on the next clock. The line stays low until an active line A edge (as selected by control bit 0) drives it high.
- R9: In line B mode 101, a port access drives line_b_out low for exactly one clock cycle, after which it returns high.
- R10: Modes 110 and 111 drive line_b_out low and high. line_b_oe is 1 in modes 1xx and 0 in modes 0xx. Both outputs follow the mode one clock after the control write.
- R11: When a flag-setting edge and a clearing event (a port access, or a flag-register write of 1) fall in the same cycle, the flag ends up set.
- R12: In mode 100, when a port access and an active line A edge fall in the same cycle, line_b_out goes or stays low.
- R13: The control register holds the line A edge select in bit 0 and the line B mode in bits 3..1. Bits 7..4 read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_rd | input | 1 | One-cycle strobe: port data register read |
| port_wr | input | 1 | One-cycle strobe: port data register write |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 flags, 2 enables, 3 none (reads 0) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register |
| line_a_in | input | 1 | Input-only control line (asynchronous) |
| line_b_in | input | 1 | Configurable control line, input side (asynchronous) |
| line_b_out | output | 1 | Configurable control line, output level |
| line_b_oe | output | 1 | Output enable for line B |
| irq | output | 1 | Interrupt request, active high |

## Verification
Two events can land in the same cycle. One is a qualified edge leaving the synchroniser; the other is a port access or a flag-register write that clears the flag. The bench sets the line change exactly three edges ahead of the strobe, so both reach the same clock edge. It then reads the flag register and expects the flag to be set. The same alignment is used in handshake mode, where a port access meets the releasing line A edge, and the output line must go low.

// File: rtl/hsk_pkg.sv
package hsk_pkg;
  localparam int REG_W  = 8;
  localparam int EN_W   = REG_W - 1;
  localparam int NLINE  = 2;
  localparam int LINE_B = 0;
  localparam int LINE_A = 1;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_FLAG = 2'd1;
  localparam logic [1:0] SEL_EN   = 2'd2;

  typedef enum logic [2:0] {
    B_IN_FALL  = 3'b000,
    B_IRQ_FALL = 3'b001,
    B_IN_RISE  = 3'b010,
    B_IRQ_RISE = 3'b011,
    B_HSK      = 3'b100,
    B_PULSE    = 3'b101,
    B_LOW      = 3'b110,
    B_HIGH     = 3'b111
  } bmode_e;
endpackage

// File: rtl/hsk_line_sync.sv
module hsk_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise,
  output logic fall
);
  // sh[STAGES-1] is the synchronised level, sh[STAGES] its previous value
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '1;
    else     sh <= {sh[STAGES-1:0], din};
  end

  assign rise =  sh[STAGES-1] & ~sh[STAGES];
  assign fall = ~sh[STAGES-1] &  sh[STAGES];
endmodule

// File: rtl/hsk_outline.sv
module hsk_outline
  import hsk_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  bmode_e mode,
  input  logic   access,
  input  logic   a_act,
  output logic   out,
  output logic   oe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out <= 1'b1;
      oe  <= 1'b0;
    end else begin
      oe <= mode[2];
      case (mode)
        B_HSK: begin
          if (access)     out <= 1'b0;
          else if (a_act) out <= 1'b1;
        end
        B_PULSE: out <= ~access;
        B_LOW:   out <= 1'b0;
        default: out <= 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/ctl_handshake_irq.sv
module ctl_handshake_irq
  import hsk_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             port_rd,
  input  logic             port_wr,
  input  logic             reg_wr,
  input  logic [1:0]       reg_sel,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             line_a_in,
  input  logic             line_b_in,
  output logic             line_b_out,
  output logic             line_b_oe,
  output logic             irq
);
  localparam int NFLAG = NLINE;

  logic [NLINE-1:0] lines, rise, fall;
  logic             a_sel_q;
  bmode_e           b_mode_q;
  logic [NFLAG-1:0] flag_q;
  logic [EN_W-1:0]  en_q;
  logic             access, a_act, b_act, b_indep, pending;
  logic             ctrl_wr, flag_wr, en_wr;
  logic [EN_W-1:0]  flags_ext;

  assign lines = {line_a_in, line_b_in};

  for (genvar gi = 0; gi < NLINE; gi++) begin : g_sync
    hsk_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .din (lines[gi]),
      .rise(rise[gi]),
      .fall(fall[gi])
    );
  end

  assign access  = port_rd | port_wr;
  assign a_act   = a_sel_q ? rise[LINE_A] : fall[LINE_A];
  assign b_act   = ~b_mode_q[2] & (b_mode_q[1] ? rise[LINE_B] : fall[LINE_B]);
  assign b_indep = ~b_mode_q[2] & b_mode_q[0];
  assign ctrl_wr = reg_wr && (reg_sel == SEL_CTRL);
  assign flag_wr = reg_wr && (reg_sel == SEL_FLAG);
  assign en_wr   = reg_wr && (reg_sel == SEL_EN);

  // control register
  always_ff @(posedge clk) begin
    if (rst) begin
      a_sel_q  <= 1'b0;
      b_mode_q <= B_IN_FALL;
    end else if (ctrl_wr) begin
      a_sel_q  <= reg_wdata[0];
      b_mode_q <= bmode_e'(reg_wdata[3:1]);
    end
  end

  // flags: a detected edge wins over any clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
    end else begin
      if (a_act)                                  flag_q[LINE_A] <= 1'b1;
      else if (access || (flag_wr && reg_wdata[LINE_A]))
                                                  flag_q[LINE_A] <= 1'b0;
      if (b_act)                                  flag_q[LINE_B] <= 1'b1;
      else if ((access && !b_indep) || (flag_wr && reg_wdata[LINE_B]))
                                                  flag_q[LINE_B] <= 1'b0;
    end
  end

  // enables: bit 7 of the write chooses set or clear
  always_ff @(posedge clk) begin
    if (rst)        en_q <= '0;
    else if (en_wr) begin
      if (reg_wdata[REG_W-1]) en_q <= en_q |  reg_wdata[EN_W-1:0];
      else                    en_q <= en_q & ~reg_wdata[EN_W-1:0];
    end
  end

  assign flags_ext = {{(EN_W-NFLAG){1'b0}}, flag_q};
  assign pending   = |(flags_ext & en_q);
  assign irq       = pending;

  always_comb begin
    case (reg_sel)
      SEL_CTRL: reg_rdata = {{(REG_W-4){1'b0}}, b_mode_q, a_sel_q};
      SEL_FLAG: reg_rdata = {pending, flags_ext};
      SEL_EN:   reg_rdata = {1'b1, en_q};
      default:  reg_rdata = '0;
    endcase
  end

  hsk_outline u_out (
    .clk   (clk),
    .rst   (rst),
    .mode  (b_mode_q),
    .access(access),
    .a_act (a_act),
    .out   (line_b_out),
    .oe    (line_b_oe)
  );
endmodule

// File: rtl/ctl_handshake_irq_chk.sv
module ctl_handshake_irq_chk (
  input logic       clk,
  input logic       rst,
  input logic       access,
  input logic       a_act,
  input logic [2:0] b_mode,
  input logic [1:0] flags,
  input logic [1:0] en,
  input logic       line_b_out,
  input logic       irq,
  input logic [1:0] reg_sel,
  input logic       rd7
);
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (line_b_out && flags == 2'b00 && !irq));

  p_set_wins_r11: assert property (@(posedge clk) disable iff (rst)
    a_act |=> flags[1]);

  p_hsk_low_r8: assert property (@(posedge clk) disable iff (rst)
    (b_mode == 3'b100 && access) |=> !line_b_out);

  p_pulse_low_r9: assert property (@(posedge clk) disable iff (rst)
    (b_mode == 3'b101 && access) |=> !line_b_out);

  p_pulse_high_r9: assert property (@(posedge clk) disable iff (rst)
    (b_mode == 3'b101 && !access) |=> line_b_out);

  p_drive_low_r10: assert property (@(posedge clk) disable iff (rst)
    (b_mode == 3'b110) |=> !line_b_out);

  p_drive_high_r10: assert property (@(posedge clk) disable iff (rst)
    (b_mode == 3'b111) |=> line_b_out);

  p_irq_needs_en_r7: assert property (@(posedge clk) disable iff (rst)
    (en == 2'b00 || flags == 2'b00) |-> !irq);

  p_flag_summary_r7: assert property (@(posedge clk) disable iff (rst)
    (reg_sel == 2'd1) |-> (rd7 == irq));

  p_en_read_r6: assert property (@(posedge clk) disable iff (rst)
    (reg_sel == 2'd2) |-> rd7);
endmodule

bind ctl_handshake_irq ctl_handshake_irq_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .access    (access),
  .a_act     (a_act),
  .b_mode    (b_mode_q),
  .flags     (flag_q),
  .en        (en_q[1:0]),
  .line_b_out(line_b_out),
  .irq       (irq),
  .reg_sel   (reg_sel),
  .rd7       (reg_rdata[7])
);

// File: tb/ctl_handshake_irq_test.sv
module ctl_handshake_irq_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       port_rd = 1'b0, port_wr = 1'b0, reg_wr = 1'b0;
  logic [1:0] reg_sel = 2'd3;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       line_a_in = 1'b1, line_b_in = 1'b1;
  logic       line_b_out, line_b_oe, irq;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;
  logic [7:0] v;

  always #5 clk = ~clk;

  ctl_handshake_irq uut (
    .clk(clk), .rst(rst), .port_rd(port_rd), .port_wr(port_wr),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .line_a_in(line_a_in), .line_b_in(line_b_in),
    .line_b_out(line_b_out), .line_b_oe(line_b_oe), .irq(irq)
  );

  // {sel, write data, expected read-back}
  localparam int NV = 8;
  localparam logic [17:0] VEC [NV] = '{
    {2'd2, 8'h83, 8'h83},
    {2'd2, 8'h01, 8'h82},
    {2'd2, 8'hFF, 8'hFF},
    {2'd2, 8'h7C, 8'h83},
    {2'd2, 8'h03, 8'h80},
    {2'd0, 8'hFF, 8'h0F},
    {2'd0, 8'h00, 8'h00},
    {2'd1, 8'hFF, 8'h00}
  };

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    cyc();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] d);
    reg_sel = s;
    #1 d = reg_rdata;
  endtask

  task automatic touch();
    port_rd = 1'b1;
    cyc();
    port_rd = 1'b0;
  endtask

  task automatic settle();
    repeat (3) cyc();
  endtask

  function automatic string vtag(input logic [1:0] s);
    if (s == 2'd2) return "R6";
    if (s == 2'd1) return "R5";
    return "R13";
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    rst = 1'b0;
    // R1 reset state
    check("R1", {7'd0, line_b_out}, 8'h01);
    check("R1", {7'd0, line_b_oe}, 8'h00);
    check("R1", {7'd0, irq}, 8'h00);
    rd(2'd0, v); check("R1", v, 8'h00);
    rd(2'd1, v); check("R1", v, 8'h00);
    rd(2'd2, v); check("R1", v, 8'h80);

    // register vector table
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][17:16], VEC[i][15:8]);
      rd(VEC[i][17:16], v);
      check(vtag(VEC[i][17:16]), v, VEC[i][7:0]);
    end

    // R2 line A falling select
    wr(2'd0, 8'h00);
    line_a_in = 1'b0; settle();
    rd(2'd1, v); check("R2", v, 8'h02);
    check("R7", {7'd0, irq}, 8'h00);
    wr(2'd2, 8'h82);
    check("R7", {7'd0, irq}, 8'h01);
    rd(2'd1, v); check("R7", v, 8'h82);
    touch();
    rd(2'd1, v); check("R5", v, 8'h00);
    check("R7", {7'd0, irq}, 8'h00);
    line_a_in = 1'b1; settle();
    rd(2'd1, v); check("R2", v, 8'h00);
    // R2 rising select
    wr(2'd0, 8'h01);
    line_a_in = 1'b0; settle();
    rd(2'd1, v); check("R2", v, 8'h00);
    line_a_in = 1'b1; settle();
    rd(2'd1, v); check("R2", v, 8'h82);
    wr(2'd1, 8'h80);
    rd(2'd1, v); check("R5", v, 8'h82);
    wr(2'd1, 8'h01);
    rd(2'd1, v); check("R5", v, 8'h82);
    wr(2'd1, 8'h02);
    rd(2'd1, v); check("R5", v, 8'h00);

    // R3 line B, flag cleared by the port
    check("R10", {7'd0, line_b_oe}, 8'h00);
    line_b_in = 1'b0; settle();
    rd(2'd1, v); check("R3", v, 8'h01);
    port_wr = 1'b1; cyc(); port_wr = 1'b0;
    rd(2'd1, v); check("R3", v, 8'h00);
    wr(2'd0, 8'h05);
    line_b_in = 1'b1; settle();
    rd(2'd1, v); check("R3", v, 8'h01);
    wr(2'd2, 8'h81);
    check("R7", {7'd0, irq}, 8'h01);
    rd(2'd1, v); check("R7", v, 8'h81);
    touch();
    rd(2'd1, v); check("R3", v, 8'h00);

    // R4 independent modes
    wr(2'd0, 8'h07);
    line_b_in = 1'b0; settle();
    rd(2'd1, v); check("R4", v, 8'h00);
    line_b_in = 1'b1; settle();
    rd(2'd1, v); check("R4", v, 8'h81);
    touch();
    rd(2'd1, v); check("R4", v, 8'h81);
    wr(2'd1, 8'h01);
    rd(2'd1, v); check("R4", v, 8'h00);
    wr(2'd0, 8'h03);
    line_b_in = 1'b0; settle();
    rd(2'd1, v); check("R4", v, 8'h81);
    touch();
    rd(2'd1, v); check("R4", v, 8'h81);
    wr(2'd1, 8'h01);
    rd(2'd1, v); check("R4", v, 8'h00);

    // R10 fixed levels
    wr(2'd0, 8'h0D); cyc();
    check("R10", {6'd0, line_b_oe, line_b_out}, 8'h02);
    wr(2'd0, 8'h0F); cyc();
    check("R10", {6'd0, line_b_oe, line_b_out}, 8'h03);

    // R8 handshake, line A rising releases
    wr(2'd0, 8'h09); cyc();
    check("R8", {7'd0, line_b_out}, 8'h01);
    touch();
    check("R8", {7'd0, line_b_out}, 8'h00);
    repeat (4) cyc();
    check("R8", {7'd0, line_b_out}, 8'h00);
    line_a_in = 1'b0; settle();
    check("R8", {7'd0, line_b_out}, 8'h00);
    line_a_in = 1'b1; settle();
    check("R8", {7'd0, line_b_out}, 8'h01);
    wr(2'd1, 8'h02);

    // R9 pulse
    wr(2'd0, 8'h0B); cyc();
    check("R9", {7'd0, line_b_out}, 8'h01);
    touch();
    check("R9", {7'd0, line_b_out}, 8'h00);
    cyc();
    check("R9", {7'd0, line_b_out}, 8'h01);

    // R11 edge meets port access
    wr(2'd0, 8'h01);
    line_a_in = 1'b0; settle();
    line_a_in = 1'b1; cyc(); cyc();
    touch();
    rd(2'd1, v); check("R11", v, 8'h82);
    touch();
    rd(2'd1, v); check("R11", v, 8'h00);
    // R11 edge meets flag write
    line_a_in = 1'b0; settle();
    line_a_in = 1'b1; cyc(); cyc();
    wr(2'd1, 8'h02);
    rd(2'd1, v); check("R11", v, 8'h82);
    wr(2'd1, 8'h02);

    // R12 handshake: access meets releasing edge
    wr(2'd0, 8'h09); cyc();
    touch();
    line_a_in = 1'b0; settle();
    line_a_in = 1'b1; cyc(); cyc();
    touch();
    check("R12", {7'd0, line_b_out}, 8'h00);
    cyc();
    check("R12", {7'd0, line_b_out}, 8'h00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule